// File: doc/BRIEF.md
# Tiled Pixmap Rectangle Engine

This block turns a rectangle command into a stream of per-pixel memory addresses. A stored pixmap is either tiled across a screen rectangle or copied into it. For every destination pixel, visited row by row and left to right, the block emits three values: the word address in pixmap memory, the bit offset of the pixel inside that word, and the linear address of the screen pixel. A separate unit is expected to read the pixmap word and write the screen pixel. Neither memory is part of this block.

A small descriptor table holds the pixmaps. Each entry is written through a define port and stores the width, height, depth code and base word address of one pixmap. Each pixmap row starts on a fresh 32-bit word. In tile mode the pixmap is locked to the screen grid. In copy mode the caller gives the pixmap coordinate that lands on the rectangle's top-left corner. In both modes the pixmap coordinate wraps at the pixmap edges. The wrap uses counters that reset at the pixmap width and height, and the block has no divider.

The host presents one command at a time on a valid/ready pair. The block rejects commands that it cannot run safely. It completes empty rectangles at once, and it reports the end of every accepted, non-empty command with a one-cycle pulse.

Top module: `pxf_engine`

## Requirements
- R1: In tile mode (`cmd_copy`=0) the pixmap pixel used for screen pixel (x, y) is (x mod W, y mod H), where W and H are the pixmap width and height. The source coordinate inputs have no effect in this mode.
- R2: In copy mode (`cmd_copy`=1) the destination pixel at column offset c and row offset r uses pixmap pixel ((src_x + c) mod W, (src_y + r) mod H). This holds for any source value, including values at or beyond the pixmap size.
- R3: The depth code D (0..5) means 2^D bits per pixel. Each pixmap row takes S = ceil(W·2^D/32) words. The pixel at (px, py) lives at word `base + py·S + ((px·2^D) >> 5)` and bit offset `(px·2^D) mod 32`.
- R4: The screen address of destination pixel (dst_x + c, dst_y + r) is `(dst_y + r)·PITCH + dst_x + c`, where PITCH = 640 by default.
- R5: An accepted non-empty command produces exactly width·height beats with `out_valid` high. Once the first beat appears, the beats come in raster order on consecutive cycles with no gap.
- R6: `cmd_done` is high for one cycle, in the cycle after the last beat, and never together with a beat.
- R7: A command with a width or height of zero produces no beat. Its `cmd_done` pulse appears in the cycle after it is accepted.
- R8: A command whose pixmap depth code differs from `scr_lg` is rejected. It gets a one-cycle `cmd_reject` pulse and produces no beat and no `cmd_done`.
- R9: A command is rejected in the same way when its id is above MAX_ID (11 by default), when its id is not defined, or when its pixmap has zero width or height. A define write with `def_keep`=0 makes an id undefined again.
- R10: After reset the outputs are low and `cmd_ready` is high. `cmd_ready` is high only while no command is in progress, so it is low during every beat. A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| def_we | input | 1 | Descriptor write strobe |
| def_keep | input | 1 | 1 defines the entry, 0 makes it undefined |
| def_id | input | ID_W | Descriptor id to write |
| def_w | input | DIM_W | Pixmap width in pixels |
| def_h | input | DIM_W | Pixmap height in rows |
| def_lg | input | 3 | Depth code, 2^code bits per pixel |
| def_base | input | ADDR_W | Pixmap base word address |
| scr_lg | input | 3 | Screen depth code |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_copy | input | 1 | 0 tile mode, 1 copy mode |
| cmd_id | input | ID_W | Pixmap id |
| cmd_src_x | input | COORD_W | Pixmap start column (copy mode) |
| cmd_src_y | input | COORD_W | Pixmap start row (copy mode) |
| cmd_dst_x | input | COORD_W | Destination left column |
| cmd_dst_y | input | COORD_W | Destination top row |
| cmd_w | input | COORD_W | Rectangle width |
| cmd_h | input | COORD_W | Rectangle height |
| out_valid | output | 1 | A pixel beat is present |
| out_rd_addr | output | ADDR_W | Pixmap word address |
| out_rd_bit | output | 5 | Bit offset of the pixel inside that word |
| out_wr_addr | output | ADDR_W | Screen pixel address |
| cmd_done | output | 1 | Command complete pulse |
| cmd_reject | output | 1 | Command refused pulse |

## Verification
Two things are hardest to reach from the ports. One is a wrap that falls in the middle of a row while the row also restarts at a different pixmap column. The other is a copy whose start coordinate lies several pixmap widths away, so the start-up reduction has to run for many cycles before the first beat. The stimulus reaches both with rectangles wider than their pixmaps that start at odd offsets. It also uses copy origins past the pixmap edges, a one-pixel pixmap that wraps on every beat, and 1-bit and 16-bit pixmaps whose rows end part way through a word. Rejection paths are reached by out-of-range, undefined, redefined-to-empty and zero-size descriptors, and by a mismatch between the pixmap depth and the screen depth.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

   // Engine control states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WRAP = 2'd1,
      ST_PREP = 2'd2,
      ST_RUN  = 2'd3
   } pxf_state_e;

   // Largest legal depth code (2^5 = 32 bits per pixel)
   localparam int unsigned LG_MAX = 5;

   // Bits per memory word, as a shift
   localparam int unsigned WORD_SH = 5;

endpackage

// File: rtl/pxf_desc_table.sv
module pxf_desc_table #(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned MAX_ID = 11,
   parameter int unsigned DIM_W  = 8,
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              def_we,
   input  logic              def_keep,
   input  logic [ID_W-1:0]   def_id,
   input  logic [DIM_W-1:0]  def_w,
   input  logic [DIM_W-1:0]  def_h,
   input  logic [2:0]        def_lg,
   input  logic [ADDR_W-1:0] def_base,
   input  logic [ID_W-1:0]   rd_id,
   output logic              rd_hit,
   output logic [DIM_W-1:0]  rd_w,
   output logic [DIM_W-1:0]  rd_h,
   output logic [2:0]        rd_lg,
   output logic [DIM_W-1:0]  rd_sw,
   output logic [ADDR_W-1:0] rd_base
);

   localparam int unsigned NUM_IDS = MAX_ID + 1;
   localparam int unsigned IDX_W   = $clog2(NUM_IDS);
   localparam int unsigned SWW     = DIM_W + 6;

   logic              v_q    [NUM_IDS];
   logic [DIM_W-1:0]  w_q    [NUM_IDS];
   logic [DIM_W-1:0]  h_q    [NUM_IDS];
   logic [2:0]        lg_q   [NUM_IDS];
   logic [DIM_W-1:0]  sw_q   [NUM_IDS];
   logic [ADDR_W-1:0] base_q [NUM_IDS];

   logic             wr_in_range, rd_in_range;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [DIM_W-1:0] sw_new;

   assign wr_in_range = (def_id <= ID_W'(MAX_ID));
   assign rd_in_range = (rd_id  <= ID_W'(MAX_ID));
   assign wr_idx      = wr_in_range ? IDX_W'(def_id) : '0;
   assign rd_idx      = rd_in_range ? IDX_W'(rd_id)  : '0;

   // Words per row: rows start word-aligned, so round the bit count up
   assign sw_new = DIM_W'(((SWW'(def_w) << def_lg) + SWW'(31)) >> pxf_pkg::WORD_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_IDS); i++) begin
            v_q[i]    <= 1'b0;
            w_q[i]    <= '0;
            h_q[i]    <= '0;
            lg_q[i]   <= '0;
            sw_q[i]   <= '0;
            base_q[i] <= '0;
         end
      end else if (def_we && wr_in_range) begin
         v_q[wr_idx]    <= def_keep;
         w_q[wr_idx]    <= def_w;
         h_q[wr_idx]    <= def_h;
         lg_q[wr_idx]   <= def_lg;
         sw_q[wr_idx]   <= sw_new;
         base_q[wr_idx] <= def_base;
      end
   end

   assign rd_hit  = rd_in_range && v_q[rd_idx] && (w_q[rd_idx] != '0) && (h_q[rd_idx] != '0);
   assign rd_w    = w_q[rd_idx];
   assign rd_h    = h_q[rd_idx];
   assign rd_lg   = lg_q[rd_idx];
   assign rd_sw   = sw_q[rd_idx];
   assign rd_base = base_q[rd_idx];

endmodule

// File: rtl/pxf_mod_reduce.sv
module pxf_mod_reduce #(
   parameter int unsigned VAL_W = 11,
   parameter int unsigned MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VAL_W-1:0] val,
   input  logic [MOD_W-1:0] modulus,
   output logic [MOD_W-1:0] res,
   output logic             settled
);

   logic [VAL_W-1:0] r_q;

   // One subtraction per cycle until the value drops below the modulus
   assign settled = (r_q < VAL_W'(modulus));
   assign res     = r_q[MOD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
      end else if (load) begin
         r_q <= val;
      end else if (!settled) begin
         r_q <= r_q - VAL_W'(modulus);
      end
   end

endmodule

// File: rtl/pxf_walker.sv
module pxf_walker #(
   parameter int unsigned DIM_W   = 8,
   parameter int unsigned COORD_W = 11,
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned PITCH   = 640
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DIM_W-1:0]   px0,
   input  logic [DIM_W-1:0]   py0,
   input  logic [DIM_W-1:0]   pw,
   input  logic [DIM_W-1:0]   ph,
   input  logic [DIM_W-1:0]   sw,
   input  logic [2:0]         lg,
   input  logic [ADDR_W-1:0]  base,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [COORD_W-1:0] w,
   input  logic [COORD_W-1:0] h,
   output logic               active,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic [4:0]         rd_bit,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic               last
);

   localparam int unsigned BW = DIM_W + 5;

   logic               act_q;
   logic [COORD_W-1:0] cx_q, cy_q;
   logic [DIM_W-1:0]   px_q, py_q, wofs_q;
   logic [4:0]         bit_q;
   logic [ADDR_W-1:0]  row_base_q, wr_q, wr_row_q;

   logic [BW-1:0]     bits0;
   logic [ADDR_W-1:0] row_scaled, wr_row0;
   logic [5:0]        step6, nbit;
   logic              col_end, row_end, px_end, py_end;

   // Bit position of the row's first pixel: column times bits per pixel
   assign bits0 = BW'(px0) << lg;

   // Screen row address: a shift when the pitch allows it, a product otherwise
   if ((PITCH & (PITCH - 1)) == 0) begin : g_pitch_shift
      localparam int unsigned PSH = $clog2(PITCH);
      assign row_scaled = ADDR_W'(dst_y) << PSH;
   end else begin : g_pitch_mult
      assign row_scaled = ADDR_W'(dst_y) * ADDR_W'(PITCH);
   end
   assign wr_row0 = row_scaled + ADDR_W'(dst_x);

   assign step6   = 6'd1 << lg;
   assign nbit    = {1'b0, bit_q} + step6;
   assign col_end = (cx_q == w - COORD_W'(1));
   assign row_end = (cy_q == h - COORD_W'(1));
   assign px_end  = (px_q == pw - DIM_W'(1));
   assign py_end  = (py_q == ph - DIM_W'(1));

   assign active  = act_q;
   assign last    = act_q && col_end && row_end;
   assign rd_addr = row_base_q + ADDR_W'(wofs_q);
   assign rd_bit  = bit_q;
   assign wr_addr = wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         cx_q       <= '0;
         cy_q       <= '0;
         px_q       <= '0;
         py_q       <= '0;
         wofs_q     <= '0;
         bit_q      <= '0;
         row_base_q <= '0;
         wr_q       <= '0;
         wr_row_q   <= '0;
      end else if (load) begin
         act_q      <= 1'b1;
         cx_q       <= '0;
         cy_q       <= '0;
         px_q       <= px0;
         py_q       <= py0;
         wofs_q     <= DIM_W'(bits0 >> pxf_pkg::WORD_SH);
         bit_q      <= bits0[4:0];
         row_base_q <= base + ADDR_W'(py0) * ADDR_W'(sw);
         wr_q       <= wr_row0;
         wr_row_q   <= wr_row0;
      end else if (act_q) begin
         if (col_end && row_end) begin
            act_q <= 1'b0;
         end else if (col_end) begin
            // next destination row: pixmap column returns to the row start
            cx_q     <= '0;
            cy_q     <= cy_q + COORD_W'(1);
            px_q     <= px0;
            wofs_q   <= DIM_W'(bits0 >> pxf_pkg::WORD_SH);
            bit_q    <= bits0[4:0];
            wr_q     <= wr_row_q + ADDR_W'(PITCH);
            wr_row_q <= wr_row_q + ADDR_W'(PITCH);
            if (py_end) begin
               py_q       <= '0;
               row_base_q <= base;
            end else begin
               py_q       <= py_q + DIM_W'(1);
               row_base_q <= row_base_q + ADDR_W'(sw);
            end
         end else begin
            cx_q <= cx_q + COORD_W'(1);
            wr_q <= wr_q + ADDR_W'(1);
            if (px_end) begin
               px_q   <= '0;
               wofs_q <= '0;
               bit_q  <= '0;
            end else begin
               px_q <= px_q + DIM_W'(1);
               if (nbit[5]) begin
                  wofs_q <= wofs_q + DIM_W'(1);
                  bit_q  <= '0;
               end else begin
                  bit_q <= nbit[4:0];
               end
            end
         end
      end
   end

endmodule

// File: rtl/pxf_engine.sv
module pxf_engine
   import pxf_pkg::*;
#(
   parameter int unsigned ID_W    = 4,
   parameter int unsigned MAX_ID  = 11,
   parameter int unsigned DIM_W   = 8,
   parameter int unsigned COORD_W = 11,
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned PITCH   = 640
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               def_we,
   input  logic               def_keep,
   input  logic [ID_W-1:0]    def_id,
   input  logic [DIM_W-1:0]   def_w,
   input  logic [DIM_W-1:0]   def_h,
   input  logic [2:0]         def_lg,
   input  logic [ADDR_W-1:0]  def_base,
   input  logic [2:0]         scr_lg,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_copy,
   input  logic [ID_W-1:0]    cmd_id,
   input  logic [COORD_W-1:0] cmd_src_x,
   input  logic [COORD_W-1:0] cmd_src_y,
   input  logic [COORD_W-1:0] cmd_dst_x,
   input  logic [COORD_W-1:0] cmd_dst_y,
   input  logic [COORD_W-1:0] cmd_w,
   input  logic [COORD_W-1:0] cmd_h,
   output logic               out_valid,
   output logic [ADDR_W-1:0]  out_rd_addr,
   output logic [4:0]         out_rd_bit,
   output logic [ADDR_W-1:0]  out_wr_addr,
   output logic               cmd_done,
   output logic               cmd_reject
);

   // Elaboration-time parameter checks
   if (MAX_ID < 1 || MAX_ID >= (1 << ID_W)) begin : g_bad_max_id
      $error("MAX_ID must lie in 1 .. 2**ID_W-1");
   end
   if (DIM_W > COORD_W) begin : g_bad_dim
      $error("DIM_W must not exceed COORD_W");
   end
   if (PITCH < 1 || ADDR_W < COORD_W) begin : g_bad_geom
      $error("PITCH must be positive and ADDR_W at least COORD_W");
   end

   pxf_state_e state_q;

   logic              tab_hit;
   logic [DIM_W-1:0]  tab_w, tab_h, tab_sw;
   logic [2:0]        tab_lg;
   logic [ADDR_W-1:0] tab_base;

   logic [DIM_W-1:0]   pw_q, ph_q, sw_q;
   logic [2:0]         lg_q;
   logic [ADDR_W-1:0]  base_q;
   logic [COORD_W-1:0] dx_q, dy_q, w_q, h_q;
   logic               done_q, rej_q;

   logic               idle, bad, empty, red_load;
   logic [COORD_W-1:0] start_x, start_y;
   logic [DIM_W-1:0]   px0, py0;
   logic               sx_ok, sy_ok, walk_last;

   pxf_desc_table #(
      .ID_W   (ID_W),
      .MAX_ID (MAX_ID),
      .DIM_W  (DIM_W),
      .ADDR_W (ADDR_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .def_we   (def_we),
      .def_keep (def_keep),
      .def_id   (def_id),
      .def_w    (def_w),
      .def_h    (def_h),
      .def_lg   (def_lg),
      .def_base (def_base),
      .rd_id    (cmd_id),
      .rd_hit   (tab_hit),
      .rd_w     (tab_w),
      .rd_h     (tab_h),
      .rd_lg    (tab_lg),
      .rd_sw    (tab_sw),
      .rd_base  (tab_base)
   );

   assign idle      = (state_q == ST_IDLE);
   assign cmd_ready = idle;
   assign bad       = !tab_hit || (tab_lg != scr_lg);
   assign empty     = (cmd_w == '0) || (cmd_h == '0);
   assign red_load  = idle && cmd_valid && !bad && !empty;
   // tile mode anchors the pixmap to the screen, copy mode to the given origin
   assign start_x   = cmd_copy ? cmd_src_x : cmd_dst_x;
   assign start_y   = cmd_copy ? cmd_src_y : cmd_dst_y;

   pxf_mod_reduce #(.VAL_W(COORD_W), .MOD_W(DIM_W)) u_red_x (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (red_load),
      .val     (start_x),
      .modulus (pw_q),
      .res     (px0),
      .settled (sx_ok)
   );

   pxf_mod_reduce #(.VAL_W(COORD_W), .MOD_W(DIM_W)) u_red_y (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (red_load),
      .val     (start_y),
      .modulus (ph_q),
      .res     (py0),
      .settled (sy_ok)
   );

   pxf_walker #(
      .DIM_W   (DIM_W),
      .COORD_W (COORD_W),
      .ADDR_W  (ADDR_W),
      .PITCH   (PITCH)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (state_q == ST_PREP),
      .px0     (px0),
      .py0     (py0),
      .pw      (pw_q),
      .ph      (ph_q),
      .sw      (sw_q),
      .lg      (lg_q),
      .base    (base_q),
      .dst_x   (dx_q),
      .dst_y   (dy_q),
      .w       (w_q),
      .h       (h_q),
      .active  (out_valid),
      .rd_addr (out_rd_addr),
      .rd_bit  (out_rd_bit),
      .wr_addr (out_wr_addr),
      .last    (walk_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         rej_q   <= 1'b0;
         pw_q    <= '0;
         ph_q    <= '0;
         sw_q    <= '0;
         lg_q    <= '0;
         base_q  <= '0;
         dx_q    <= '0;
         dy_q    <= '0;
         w_q     <= '0;
         h_q     <= '0;
      end else begin
         done_q <= 1'b0;
         rej_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (bad) begin
                     rej_q <= 1'b1;
                  end else if (empty) begin
                     done_q <= 1'b1;
                  end else begin
                     pw_q    <= tab_w;
                     ph_q    <= tab_h;
                     sw_q    <= tab_sw;
                     lg_q    <= tab_lg;
                     base_q  <= tab_base;
                     dx_q    <= cmd_dst_x;
                     dy_q    <= cmd_dst_y;
                     w_q     <= cmd_w;
                     h_q     <= cmd_h;
                     state_q <= ST_WRAP;
                  end
               end
            end
            ST_WRAP: begin
               if (sx_ok && sy_ok) state_q <= ST_PREP;
            end
            ST_PREP: state_q <= ST_RUN;
            ST_RUN: begin
               if (walk_last) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_done   = done_q;
   assign cmd_reject = rej_q;

endmodule

// File: rtl/pxf_engine_chk.sv
module pxf_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       out_valid,
   input logic       cmd_ready,
   input logic       cmd_done,
   input logic       cmd_reject,
   input logic [4:0] out_rd_bit,
   input logic [2:0] act_lg
);

   // R10: no command can be taken while beats are flowing
   a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !cmd_ready);

   // R6: the completion pulse never overlaps a pixel beat
   a_r6_done_after_beats: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !out_valid);

   // R8: a refused command emits nothing and leaves the engine idle
   a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> (!out_valid && cmd_ready));

   // R9: a refusal is never also a completion
   a_r9_reject_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_reject && cmd_done));

   // R3: bit offsets are whole multiples of the pixel size
   a_r3_bit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (({1'b0, out_rd_bit} & ((6'd1 << act_lg) - 6'd1)) == 6'd0));

   // R7: the block never produces a beat in the cycle after a zero-size or rejected pulse
   a_r7_no_beat_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done || cmd_reject) |=> !out_valid);

endmodule

bind pxf_engine pxf_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .cmd_ready  (cmd_ready),
   .cmd_done   (cmd_done),
   .cmd_reject (cmd_reject),
   .out_rd_bit (out_rd_bit),
   .act_lg     (lg_q)
);

// File: tb/pxf_engine_tb.sv
`timescale 1ns/1ps
module pxf_engine_tb;

   localparam int ID_W    = 4;
   localparam int MAX_ID  = 11;
   localparam int DIM_W   = 8;
   localparam int COORD_W = 11;
   localparam int ADDR_W  = 24;
   localparam int PITCH   = 640;

   logic               clk, rst_n;
   logic               def_we, def_keep;
   logic [ID_W-1:0]    def_id;
   logic [DIM_W-1:0]   def_w, def_h;
   logic [2:0]         def_lg, scr_lg;
   logic [ADDR_W-1:0]  def_base;
   logic               cmd_valid, cmd_ready, cmd_copy;
   logic [ID_W-1:0]    cmd_id;
   logic [COORD_W-1:0] cmd_src_x, cmd_src_y, cmd_dst_x, cmd_dst_y, cmd_w, cmd_h;
   logic               out_valid, cmd_done, cmd_reject;
   logic [ADDR_W-1:0]  out_rd_addr, out_wr_addr;
   logic [4:0]         out_rd_bit;

   pxf_engine #(
      .ID_W(ID_W), .MAX_ID(MAX_ID), .DIM_W(DIM_W),
      .COORD_W(COORD_W), .ADDR_W(ADDR_W), .PITCH(PITCH)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .def_we(def_we), .def_keep(def_keep), .def_id(def_id),
      .def_w(def_w), .def_h(def_h), .def_lg(def_lg), .def_base(def_base),
      .scr_lg(scr_lg),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_copy(cmd_copy),
      .cmd_id(cmd_id), .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y),
      .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
      .out_valid(out_valid), .out_rd_addr(out_rd_addr), .out_rd_bit(out_rd_bit),
      .out_wr_addr(out_wr_addr), .cmd_done(cmd_done), .cmd_reject(cmd_reject)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int    total = 0, bad = 0, cyc = 0;
   bit    finished = 0, started = 0;
   int    rq[$], bq[$], wq[$];
   int    done_pend = 0, rej_pend = 0;
   string tag = "R1", dtag = "R6", rtag = "R9";
   int    dw[16], dh[16], dl[16], db[16];
   bit    dv[16];

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // Reference comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (rq.size() == 0) begin
               check(0, "R5", "unexpected beat", 1, 0);
            end else begin
               check(int'(out_rd_addr) == rq[0], tag, "pixmap word (R3)", out_rd_addr, rq[0]);
               check(int'(out_rd_bit) == bq[0], tag, "bit offset (R3)", out_rd_bit, bq[0]);
               check(int'(out_wr_addr) == wq[0], "R4", "screen address", out_wr_addr, wq[0]);
               void'(rq.pop_front()); void'(bq.pop_front()); void'(wq.pop_front());
            end
            started = 1;
         end else if (started && rq.size() > 0) begin
            check(0, "R5", "gap in beat stream", 0, 1);
         end
         if (cmd_done) begin
            check(done_pend > 0 && rq.size() == 0, dtag, "done timing", rq.size(), 0);
            if (done_pend > 0) done_pend--;
            started = 0;
         end
         if (cmd_reject) begin
            check(rej_pend > 0, rtag, "unexpected reject", 1, 0);
            if (rej_pend > 0) rej_pend--;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic def_pm(int id, int w, int h, int lg, int base, bit keep);
      @(negedge clk);
      def_we = 1; def_keep = keep; def_id = ID_W'(id);
      def_w = DIM_W'(w); def_h = DIM_W'(h); def_lg = 3'(lg); def_base = ADDR_W'(base);
      @(posedge clk); #1;
      def_we = 0;
      if (id <= MAX_ID) begin
         dv[id] = keep; dw[id] = w; dh[id] = h; dl[id] = lg; db[id] = base;
      end
   endtask

   task automatic run_cmd(string t, bit cp, int id, int sx, int sy, int dx, int dy, int w, int h);
      bit refuse;
      @(negedge clk);
      tag = t;
      refuse = (id > MAX_ID) || !dv[id] || dw[id] == 0 || dh[id] == 0 || dl[id] != int'(scr_lg);
      if (refuse) begin
         rej_pend++;
      end else if (w == 0 || h == 0) begin
         dtag = "R7";
         done_pend++;
      end else begin
         int sw;
         dtag = "R6";
         sw = ((dw[id] << dl[id]) + 31) >> 5;
         for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
               int px, py, ba;
               px = ((cp ? sx : dx) + c) % dw[id];
               py = ((cp ? sy : dy) + r) % dh[id];
               ba = px << dl[id];
               rq.push_back(db[id] + py * sw + (ba >> 5));
               bq.push_back(ba & 31);
               wq.push_back((dy + r) * PITCH + dx + c);
            end
         end
         done_pend++;
      end
      cmd_copy = cp; cmd_id = ID_W'(id);
      cmd_src_x = COORD_W'(sx); cmd_src_y = COORD_W'(sy);
      cmd_dst_x = COORD_W'(dx); cmd_dst_y = COORD_W'(dy);
      cmd_w = COORD_W'(w); cmd_h = COORD_W'(h);
      check(cmd_ready, "R10", "ready before command", cmd_ready, 1);
      cmd_valid = 1;
      @(posedge clk); #1;
      cmd_valid = 0;
      for (int i = 0; i < 4000 && (done_pend > 0 || rej_pend > 0); i++) @(negedge clk);
      if (done_pend > 0 || rej_pend > 0) begin
         check(0, refuse ? rtag : dtag, "completion pulse missing", 0, 1);
         done_pend = 0; rej_pend = 0;
      end
      check(rq.size() == 0, "R5", "beats left over", rq.size(), 0);
      rq.delete(); bq.delete(); wq.delete();
      started = 0;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         dv[i] = 0; dw[i] = 0; dh[i] = 0; dl[i] = 0; db[i] = 0;
      end
      rst_n = 0; def_we = 0; def_keep = 0; def_id = '0; def_w = '0; def_h = '0;
      def_lg = '0; def_base = '0; scr_lg = 3'd3; cmd_valid = 0; cmd_copy = 0;
      cmd_id = '0; cmd_src_x = '0; cmd_src_y = '0; cmd_dst_x = '0; cmd_dst_y = '0;
      cmd_w = '0; cmd_h = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!out_valid, "R10", "reset out_valid", out_valid, 0);
      check(!cmd_done, "R10", "reset cmd_done", cmd_done, 0);
      check(!cmd_reject, "R10", "reset cmd_reject", cmd_reject, 0);
      check(cmd_ready, "R10", "reset cmd_ready", cmd_ready, 1);

      def_pm(0, 5, 3, 3, 'h100, 1);
      def_pm(1, 13, 4, 0, 'h200, 1);
      def_pm(2, 7, 2, 4, 'h400, 1);
      def_pm(3, 4, 4, 2, 'h500, 1);
      def_pm(5, 33, 2, 3, 'h800, 1);
      def_pm(6, 1, 1, 3, 'h900, 1);
      def_pm(7, 0, 3, 3, 'hA00, 1);

      // R1: tile mode, source fields set to junk that must be ignored
      run_cmd("R1", 0, 0, 999, 777, 17, 9, 6, 4);
      run_cmd("R1", 0, 5, 3, 3, 30, 1, 8, 3);
      // R2: copy mode with origins inside and far outside the pixmap
      run_cmd("R2", 1, 0, 3, 2, 100, 50, 7, 5);
      run_cmd("R2", 1, 0, 12, 7, 0, 0, 4, 4);
      run_cmd("R2", 1, 5, 70, 5, 3, 8, 40, 2);
      // R3: 1-bit and 16-bit pixmaps, rows ending part way through a word
      scr_lg = 3'd0;
      run_cmd("R3", 0, 1, 0, 0, 5, 0, 20, 2);
      scr_lg = 3'd4;
      run_cmd("R3", 1, 2, 6, 1, 10, 10, 9, 3);
      scr_lg = 3'd3;
      // R5: one-pixel pixmap wraps on every beat; a single-pixel rectangle
      run_cmd("R5", 0, 6, 0, 0, 2, 2, 3, 2);
      run_cmd("R5", 1, 5, 32, 1, 9, 9, 1, 1);
      // R7: empty rectangles
      run_cmd("R7", 0, 0, 0, 0, 4, 4, 0, 3);
      run_cmd("R7", 1, 0, 1, 1, 4, 4, 5, 0);
      // R8: depth mismatch
      rtag = "R8";
      run_cmd("R8", 0, 3, 0, 0, 1, 1, 2, 2);
      // R9: out of range, undefined, zero-size descriptor, undefined again
      rtag = "R9";
      run_cmd("R9", 0, 14, 0, 0, 1, 1, 2, 2);
      run_cmd("R9", 0, 9, 0, 0, 1, 1, 2, 2);
      run_cmd("R9", 0, 7, 0, 0, 1, 1, 2, 2);
      def_pm(0, 5, 3, 3, 'h100, 0);
      run_cmd("R9", 1, 0, 0, 0, 1, 1, 2, 2);
      // R1: engine still works after refusals
      run_cmd("R1", 0, 5, 0, 0, 31, 4, 5, 2);

      repeat (4) @(negedge clk);
      summary();
   end

endmodule